// File: doc/BRIEF.md
# Frame-Rate Referenced Digital Clock Recovery Loop

This block recovers a steady clock enable from a reference that ticks only once per frame, a few milliseconds apart. A numerically controlled oscillator runs on the master clock. It adds a frequency word into a phase accumulator on every cycle, and each carry out of the accumulator becomes a one-cycle output enable. A local frame counter divides these enables down to the nominal frame length. On every received frame-sync pulse, the block captures the position of the local counter as a signed phase error. That error drives a proportional-plus-integral filter, and the filter output trims the frequency word.

Loop gain is set by a 5-bit code. Code zero stops all correction and leaves the frequency word where it is. Code n (1..31) scales both filter paths by 2^-(n-1), using an arithmetic right shift. A low code locks fast but passes more reference jitter. Each higher code halves the loop bandwidth, which lengthens the lock time and improves jitter rejection. A lock indicator with hysteresis reports when the loop has settled.

Top module: `fdpll_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `clk_en` is 0, `freq_word` equals `NOM_FW`, `locked` is 0 and `phase_err` is 0.
- R2: Each cycle the unsigned `ACC_W`-bit accumulator adds `freq_word` modulo 2^ACC_W. `clk_en` is 1 in the cycle after each addition that carries out, and 0 otherwise. With `freq_word` = 2^(ACC_W-2), exactly one cycle in four has `clk_en` high.
- R3: `freq_word` is registered as `NOM_FW` plus the signed filter adjustment, modulo 2^ACC_W. The adjustment changes only in the cycle after a phase error is captured, so `freq_word` changes one cycle after that.
- R4: The first `frame_sync` after reset only clears the local frame counter. It captures no error and makes no frequency correction, so `phase_err` stays 0 and `freq_word` stays `NOM_FW`.
- R5: The local counter counts `clk_en` pulses modulo `FRAME_TICKS`. On each later `frame_sync`, let c be the counter value in that cycle. The block registers `phase_err` = -c when c < FRAME_TICKS/2, and `phase_err` = FRAME_TICKS - c otherwise. A positive value means the local frame lags the reference.
- R6: When the gain code is 0 as a captured error is processed, the integrator and the adjustment keep their values, so `freq_word` does not change.
- R7: When the gain code is n ≥ 1, the step is p = (phase_err · 2^ERR_SHL) >>> (n-1), clamped to signed `ACC_W` bits. The new integrator is the clamp of (integrator + p). The new adjustment is the clamp of (new integrator + p).
- R8: The integrator and the adjustment saturate at -2^(ACC_W-1) and 2^(ACC_W-1)-1. Sustained positive errors drive `freq_word` to `NOM_FW` + 2^(ACC_W-1) - 1.
- R9: `locked` rises in the cycle after the `LOCK_FRAMES`-th consecutive captured error with |error| < `lock_thr`.
- R10: A captured error with |error| > 2·`lock_thr` clears `locked` in the next cycle and restarts the count. An error in the band between the two limits restarts the count but leaves `locked` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock driving the oscillator |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | One-cycle pulse at each received frame boundary |
| gain_code | input | 5 | Loop gain code: 0 freezes, n gives 2^-(n-1) |
| lock_thr | input | THR_W | Error magnitude below which a frame counts as good |
| clk_en | output | 1 | Recovered clock enable, one cycle per oscillator carry |
| freq_word | output | ACC_W | Current oscillator frequency word |
| locked | output | 1 | Loop lock indication |
| phase_err | output | ERR_W | Last captured signed phase error, in output ticks |

## Verification
The bench builds the block with a nominal word of 2^30 and `FRAME_TICKS` = 16, so one nominal frame lasts 64 master clocks. This puts many frames, the lock and unlock cases, and gain-code sweeps within a short run. `ERR_SHL` = 26 gives an error of a few ticks enough weight to reach integrator saturation within four frames at gain code 1. A threshold of 2 places the good, middle and bad error bands only a few ticks apart. The bench also times frame pulses from its own model's counter position, which makes the sign and size of the error certain.

// File: rtl/fdpll_pkg.sv
package fdpll_pkg;
  localparam int GAIN_W = 5;
  typedef logic [GAIN_W-1:0] gain_code_t;
  localparam gain_code_t GAIN_HOLD = '0;
endpackage

// File: rtl/fdpll_nco.sv
module fdpll_nco #(
  parameter int unsigned ACC_W = 32,
  parameter logic [ACC_W-1:0] NOM_FW = 32'h0008_8889
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] adj,
  output logic [ACC_W-1:0]        freq_word,
  output logic                    tick
);
  logic [ACC_W-1:0] phase_acc;
  logic [ACC_W:0]   acc_sum;

  assign acc_sum = {1'b0, phase_acc} + {1'b0, freq_word};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_acc <= '0;
      tick      <= 1'b0;
      freq_word <= NOM_FW;
    end else begin
      phase_acc <= acc_sum[ACC_W-1:0];
      tick      <= acc_sum[ACC_W];
      freq_word <= NOM_FW + $unsigned(adj);
    end
  end

  // R3: word only moves when the filter adjustment moved one cycle earlier
  p_word_tracks_adj_r3: assert property (@(posedge clk) disable iff (rst)
    $stable(adj) |=> $stable(freq_word));
endmodule

// File: rtl/fdpll_phase_det.sv
module fdpll_phase_det #(
  parameter int unsigned FRAME_TICKS = 48,
  parameter int unsigned ERR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    frame_sync,
  output logic signed [ERR_W-1:0] err,
  output logic                    err_v
);
  localparam int unsigned CNT_W = (FRAME_TICKS > 2) ? $clog2(FRAME_TICKS) : 1;
  localparam int unsigned HALF  = FRAME_TICKS / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_TICKS - 1);

  logic [CNT_W-1:0]        frame_cnt;
  logic [CNT_W-1:0]        cnt_step;
  logic                    aligned;
  logic signed [ERR_W-1:0] err_now;

  assign cnt_step = (frame_cnt == LAST) ? '0 : frame_cnt + 1'b1;

  always_comb begin
    if (int'(frame_cnt) < int'(HALF))
      err_now = ERR_W'(-int'(frame_cnt));
    else
      err_now = ERR_W'(int'(FRAME_TICKS) - int'(frame_cnt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_cnt <= '0;
      aligned   <= 1'b0;
      err       <= '0;
      err_v     <= 1'b0;
    end else begin
      err_v <= 1'b0;
      if (tick) frame_cnt <= cnt_step;
      if (frame_sync) begin
        if (!aligned) begin
          frame_cnt <= '0;
          aligned   <= 1'b1;
        end else begin
          err   <= err_now;
          err_v <= 1'b1;
        end
      end
    end
  end

  // R4: aligning pulse produces no error event
  p_first_sync_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (frame_sync && !aligned) |=> !err_v);
  // R5: counter stays inside one frame
  p_cnt_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
    int'(frame_cnt) < int'(FRAME_TICKS));
endmodule

// File: rtl/fdpll_loop_filter.sv
module fdpll_loop_filter
  import fdpll_pkg::*;
#(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned ERR_W = 16,
  parameter int unsigned ERR_SHL = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ERR_W-1:0] err,
  input  logic                    err_v,
  input  gain_code_t              gain,
  output logic signed [ACC_W-1:0] adj
);
  localparam int unsigned SC_W  = ERR_W + ERR_SHL;
  localparam int unsigned SUM_W = ACC_W + 2;
  localparam int unsigned BIG_W = ((SC_W > SUM_W) ? SC_W : SUM_W) + 1;
  localparam logic signed [BIG_W-1:0] MAXV =
    {{(BIG_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [BIG_W-1:0] MINV = ~MAXV;

  function automatic logic signed [ACC_W-1:0] clamp(input logic signed [BIG_W-1:0] v);
    if (v > MAXV)      return MAXV[ACC_W-1:0];
    else if (v < MINV) return MINV[ACC_W-1:0];
    else               return v[ACC_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] integ;
  logic signed [SC_W-1:0]  scaled;
  logic signed [SC_W-1:0]  shifted;
  logic [GAIN_W-1:0]       shamt;
  logic signed [ACC_W-1:0] step;
  logic signed [ACC_W-1:0] integ_nxt;
  logic signed [ACC_W-1:0] adj_nxt;

  assign scaled    = $signed({err, {ERR_SHL{1'b0}}});
  assign shamt     = gain - 1'b1;
  assign shifted   = scaled >>> shamt;
  assign step      = clamp(BIG_W'(shifted));
  assign integ_nxt = clamp(BIG_W'(integ) + BIG_W'(step));
  assign adj_nxt   = clamp(BIG_W'(integ_nxt) + BIG_W'(step));

  always_ff @(posedge clk) begin
    if (rst) begin
      integ <= '0;
      adj   <= '0;
    end else if (err_v && gain != GAIN_HOLD) begin
      integ <= integ_nxt;
      adj   <= adj_nxt;
    end
  end

  // R6: frozen gain leaves integrator and adjustment untouched
  p_freeze_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (err_v && gain == GAIN_HOLD) |=> ($stable(integ) && $stable(adj)));
  // R3: adjustment moves only after a captured error
  p_adj_on_event_r3: assert property (@(posedge clk) disable iff (rst)
    !err_v |=> $stable(adj));
endmodule

// File: rtl/fdpll_lock_mon.sv
module fdpll_lock_mon #(
  parameter int unsigned ERR_W = 16,
  parameter int unsigned THR_W = 8,
  parameter int unsigned LOCK_FRAMES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ERR_W-1:0] err,
  input  logic                    err_v,
  input  logic [THR_W-1:0]        thr,
  output logic                    locked
);
  localparam int unsigned CMP_W = ((ERR_W > THR_W + 1) ? ERR_W : THR_W + 1) + 1;
  localparam int unsigned GD_W  = $clog2(LOCK_FRAMES + 1);
  localparam logic [GD_W-1:0] GOAL = GD_W'(LOCK_FRAMES);

  logic [CMP_W-1:0] mag;
  logic [CMP_W-1:0] lim_lo;
  logic [CMP_W-1:0] lim_hi;
  logic [GD_W-1:0]  good_run;
  logic [GD_W-1:0]  good_inc;
  logic             is_good;
  logic             is_bad;

  assign mag      = err[ERR_W-1] ? CMP_W'(-$signed({err[ERR_W-1], err}))
                                 : CMP_W'($unsigned(err));
  assign lim_lo   = CMP_W'(thr);
  assign lim_hi   = CMP_W'({thr, 1'b0});
  assign is_good  = mag < lim_lo;
  assign is_bad   = mag > lim_hi;
  assign good_inc = (good_run == GOAL) ? GOAL : good_run + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      good_run <= '0;
      locked   <= 1'b0;
    end else if (err_v) begin
      if (is_bad) begin
        good_run <= '0;
        locked   <= 1'b0;
      end else if (is_good) begin
        good_run <= good_inc;
        if (good_inc == GOAL) locked <= 1'b1;
      end else begin
        good_run <= '0;
      end
    end
  end

  // R9: lock can only appear right after a captured error
  p_lock_rise_event_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(err_v));
  // R10: a large error always drops lock
  p_big_err_unlocks_r10: assert property (@(posedge clk) disable iff (rst)
    (err_v && is_bad) |=> !locked);
endmodule

// File: rtl/fdpll_top.sv
module fdpll_top
  import fdpll_pkg::*;
#(
  parameter int unsigned ACC_W = 32,
  parameter logic [ACC_W-1:0] NOM_FW = 32'h0008_8889,
  parameter int unsigned FRAME_TICKS = 48,
  parameter int unsigned ERR_W = 16,
  parameter int unsigned ERR_SHL = 16,
  parameter int unsigned THR_W = 8,
  parameter int unsigned LOCK_FRAMES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_sync,
  input  logic [4:0]       gain_code,
  input  logic [THR_W-1:0] lock_thr,
  output logic             clk_en,
  output logic [ACC_W-1:0] freq_word,
  output logic             locked,
  output logic [ERR_W-1:0] phase_err
);
  logic signed [ACC_W-1:0] adj;
  logic signed [ERR_W-1:0] err;
  logic                    err_v;

  fdpll_nco #(.ACC_W(ACC_W), .NOM_FW(NOM_FW)) u_nco (
    .clk(clk), .rst(rst), .adj(adj), .freq_word(freq_word), .tick(clk_en)
  );

  fdpll_phase_det #(.FRAME_TICKS(FRAME_TICKS), .ERR_W(ERR_W)) u_pd (
    .clk(clk), .rst(rst), .tick(clk_en), .frame_sync(frame_sync),
    .err(err), .err_v(err_v)
  );

  fdpll_loop_filter #(.ACC_W(ACC_W), .ERR_W(ERR_W), .ERR_SHL(ERR_SHL)) u_lf (
    .clk(clk), .rst(rst), .err(err), .err_v(err_v),
    .gain(gain_code_t'(gain_code)), .adj(adj)
  );

  fdpll_lock_mon #(.ERR_W(ERR_W), .THR_W(THR_W), .LOCK_FRAMES(LOCK_FRAMES)) u_lm (
    .clk(clk), .rst(rst), .err(err), .err_v(err_v), .thr(lock_thr),
    .locked(locked)
  );

  assign phase_err = err;
endmodule

// File: tb/fdpll_top_test.sv
module fdpll_top_test;
  localparam int ACC_W = 32;
  localparam longint NOM = 64'h4000_0000;
  localparam int FT = 16;
  localparam int ERR_W = 16;
  localparam int SHL = 26;
  localparam int THR_W = 8;
  localparam int LF = 4;
  localparam longint MASK = 64'hFFFF_FFFF;
  localparam longint MAXI = 64'sd2147483647;
  localparam longint MINI = -64'sd2147483648;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_sync = 1'b0;
  logic [4:0] gain_code = 5'd8;
  logic [THR_W-1:0] lock_thr = 8'd2;
  logic clk_en;
  logic [ACC_W-1:0] freq_word;
  logic locked;
  logic [ERR_W-1:0] phase_err;

  fdpll_top #(.ACC_W(ACC_W), .NOM_FW(32'h4000_0000), .FRAME_TICKS(FT),
              .ERR_W(ERR_W), .ERR_SHL(SHL), .THR_W(THR_W), .LOCK_FRAMES(LF)) uut (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .gain_code(gain_code),
    .lock_thr(lock_thr), .clk_en(clk_en), .freq_word(freq_word),
    .locked(locked), .phase_err(phase_err)
  );

  always #5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit started = 1'b0;
  bit sat_seen = 1'b0;

  // behavioural reference state
  longint m_acc, m_fw, m_cnt, m_err, m_integ, m_adj, m_good;
  bit m_tick, m_aligned, m_errv, m_lock;

  function automatic longint clampv(longint v);
    if (v > MAXI) return MAXI;
    if (v < MINI) return MINI;
    return v;
  endfunction

  always @(posedge clk) begin : ref_model
    longint sum, n_acc, n_fw, n_cnt, n_err, n_integ, n_adj, n_good, p, a;
    bit n_tick, n_aligned, n_errv, n_lock;
    if (rst) begin
      m_acc = 0; m_fw = NOM; m_cnt = 0; m_err = 0; m_integ = 0; m_adj = 0;
      m_good = 0; m_tick = 0; m_aligned = 0; m_errv = 0; m_lock = 0;
    end else begin
      sum = m_acc + m_fw;
      n_acc = sum & MASK;
      n_tick = (sum > MASK);
      n_fw = (NOM + m_adj) & MASK;
      n_cnt = m_tick ? (m_cnt + 1) % FT : m_cnt;
      n_aligned = m_aligned; n_err = m_err; n_errv = 0;
      if (frame_sync) begin
        if (!m_aligned) begin
          n_cnt = 0; n_aligned = 1;
        end else begin
          n_err = (m_cnt < FT / 2) ? -m_cnt : FT - m_cnt;
          n_errv = 1;
        end
      end
      n_integ = m_integ; n_adj = m_adj;
      if (m_errv && gain_code != 0) begin
        p = clampv((m_err <<< SHL) >>> (gain_code - 1));
        n_integ = clampv(m_integ + p);
        n_adj = clampv(n_integ + p);
        if (n_integ == MAXI) sat_seen = 1'b1;
      end
      n_good = m_good; n_lock = m_lock;
      if (m_errv) begin
        a = (m_err < 0) ? -m_err : m_err;
        if (a > 2 * longint'(lock_thr)) begin
          n_good = 0; n_lock = 0;
        end else if (a < longint'(lock_thr)) begin
          n_good = (m_good >= LF) ? LF : m_good + 1;
          if (n_good == LF) n_lock = 1;
        end else begin
          n_good = 0;
        end
      end
      m_acc = n_acc; m_tick = n_tick; m_fw = n_fw; m_cnt = n_cnt;
      m_aligned = n_aligned; m_err = n_err; m_errv = n_errv;
      m_integ = n_integ; m_adj = n_adj; m_good = n_good; m_lock = n_lock;
    end
    started = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (started) begin
      chk(clk_en == m_tick, "R2 clk_en", longint'(clk_en), longint'(m_tick));
      chk(longint'(freq_word) == m_fw, "R3 R7 freq_word", longint'(freq_word), m_fw);
      chk(longint'($signed(phase_err)) == m_err, "R5 phase_err",
          longint'($signed(phase_err)), m_err);
      chk(locked == m_lock, "R9 R10 locked", longint'(locked), longint'(m_lock));
    end
  end

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary_and_end();
    end
  end

  task automatic pulse();
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  initial begin : stim
    int ticks;
    logic [ACC_W-1:0] held;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(clk_en == 1'b0, "R1 clk_en", longint'(clk_en), 0);
    chk(freq_word == 32'h4000_0000, "R1 freq_word", longint'(freq_word), NOM);
    chk(locked == 1'b0, "R1 locked", longint'(locked), 0);
    chk(phase_err == '0, "R1 phase_err", longint'(phase_err), 0);
    rst = 1'b0;
    repeat (7) @(negedge clk);
    // R4 first pulse only aligns
    pulse();
    repeat (5) @(negedge clk);
    chk(phase_err == '0, "R4 phase_err", longint'($signed(phase_err)), 0);
    chk(freq_word == 32'h4000_0000, "R4 freq_word", longint'(freq_word), NOM);
    // R2 quarter-rate enables at nominal word
    ticks = 0;
    for (int i = 0; i < 40; i++) begin
      ticks += int'(clk_en);
      @(negedge clk);
    end
    chk(ticks == 10, "R2 tick count", ticks, 10);
    repeat (18) @(negedge clk);
    // R9 nominal frames acquire lock
    for (int f = 0; f < 5; f++) begin
      pulse();
      repeat (63) @(negedge clk);
    end
    chk(locked == 1'b1, "R9 lock acquired", longint'(locked), 1);
    // R10 large offset drops lock
    repeat (24) @(negedge clk);
    pulse();
    repeat (4) @(negedge clk);
    chk(locked == 1'b0, "R10 lock lost", longint'(locked), 0);
    chk($signed(phase_err) < -16'sd4 || $signed(phase_err) > 16'sd4, "R10 error size",
        longint'($signed(phase_err)), 6);
    // R6 freeze
    gain_code = 5'd0;
    repeat (10) @(negedge clk);
    held = freq_word;
    for (int f = 0; f < 3; f++) begin
      repeat (49) @(negedge clk);
      pulse();
      repeat (5) @(negedge clk);
      chk(freq_word == held, "R6 frozen word", longint'(freq_word), longint'(held));
    end
    // R7 gain sweep, checked cycle by cycle
    gain_code = 5'd31;
    for (int f = 0; f < 3; f++) begin
      repeat (69) @(negedge clk);
      pulse();
    end
    gain_code = 5'd12;
    for (int f = 0; f < 3; f++) begin
      repeat (57) @(negedge clk);
      pulse();
    end
    // R8 saturation with sustained positive error
    gain_code = 5'd1;
    for (int f = 0; f < 8; f++) begin
      while (m_cnt != FT / 2) @(negedge clk);
      pulse();
      repeat (6) @(negedge clk);
    end
    chk(sat_seen, "R8 integrator clamp reached", longint'(sat_seen), 1);
    chk(longint'(freq_word) == ((NOM + MAXI) & MASK), "R8 saturated word",
        longint'(freq_word), (NOM + MAXI) & MASK);
    repeat (20) @(negedge clk);
    summary_and_end();
  end
endmodule